// File: doc/BRIEF.md
# Serial Input Bit-Delay and Sampling Aligner

The block receives one serial input stream running at a quarter of the internal clock-enable rate: every data bit spans four enable ticks. A frame boundary strobe marks tick zero of the input frame. A 5-bit delay code, reinterpreted by a sampling-mode select, shifts the point inside the frame where channel 0, bit 0 is taken to begin. It also chooses the quarter of each bit at which the line is sampled. Sampled bits are gathered eight at a time into channel bytes, which leave the block with the index of the channel they belong to (0 to 511) and a one-clock valid pulse.

The delay and mode are captured only on the frame boundary tick, so software may rewrite them at any time and the change lands cleanly on the next frame. Channel numbering follows the delayed frame position. The last channel of one delayed frame is followed by channel 0 of the next.

Top module: `serial_bit_aligner`

## Requirements
- R1: While `rst` is high, and after it until the first frame boundary tick has been taken, `byte_vld` stays 0, and `byte_data` and `byte_chan` read 0. Bits that fall on the first boundary tick itself are not captured.
- R2: With `smp_mode` = 1 the capture offset in ticks equals the code value, 4*code[4:2] + code[1:0]: an integer delay of code[4:2] bits plus a sampling point code[1:0] of 0..3 quarter ticks. Bit k of the delayed frame is captured at tick 4*k + offset after the boundary tick (tick 0).
- R3: With `smp_mode` = 0 the offset is 2*code[3:0] + 2 ticks, a half-bit-step delay of up to 7 1/2 bits with the sample taken on the third tick of each bit; code[4] has no effect in this mode.
- R4: The first bit captured for a channel lands in `byte_data[7]` and the last in `byte_data[0]` (MSB first). A code of 0 in quarter mode captures on the boundary tick's own bit timing, with no delay.
- R5: `byte_vld` is high for exactly one clock, the clock after the enable tick that captures bit 7 of a channel; `byte_chan` gives that channel's delayed index, counting 0..511 and wrapping from 511 to 0. Between pulses, `byte_data` and `byte_chan` hold.
- R6: `dly_code` and `smp_mode` are read only on a frame boundary tick; a change between boundaries has no effect until the next one.
- R7: On clocks with `tick_en` = 0 nothing advances and `sdi` is not sampled.
- R8: `frame_sync` is recognised only when `tick_en` is 1; a strobe on a clock without a tick is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Oversampling tick, four per serial bit |
| frame_sync | input | 1 | Marks tick 0 of an input frame (valid with tick_en) |
| sdi | input | 1 | Serial data bit |
| dly_code | input | 5 | Delay and sampling code |
| smp_mode | input | 1 | 1: integer bits plus quarter sampling point; 0: half-bit steps |
| byte_vld | output | 1 | One-clock pulse: a channel byte is complete |
| byte_data | output | 8 | Assembled channel byte, MSB first |
| byte_chan | output | 9 | Delayed channel index of byte_data |

## Verification
The assertions assume that frame boundary strobes arrive with a tick enable and, in steady use, exactly one frame apart in ticks; a strobe without a tick is allowed and must simply be dropped. The single-pulse property is relaxed only on boundary ticks, where a changed offset may legitimately re-enter bit 7. The stimulus keeps the boundary period fixed at a full frame of counted ticks, inserts enable gaps and one stray strobe in dedicated frames, and changes the code only at boundaries except in one frame used to show a mid-frame write is deferred.

// File: rtl/sba_pkg.sv
package sba_pkg;

    // Interpretation of the 5-bit delay code
    typedef enum logic {
        SMP_HALF_STEP = 1'b0,   // code[3:0] half-bit steps, fixed sample tick
        SMP_QUARTER   = 1'b1    // code[4:2] whole bits, code[1:0] sample quarter
    } smp_mode_e;

    localparam int CODE_W   = 5;
    localparam int OFFSET_W = 6;          // largest offset is 32 ticks

    typedef struct packed {
        logic [CODE_W-1:0] code;
        smp_mode_e         mode;
    } dly_cfg_t;

    // Ticks between the frame boundary and the first capture of bit 0.
    // Assumes four ticks per serial bit.
    function automatic logic [OFFSET_W-1:0] tick_offset(input dly_cfg_t cfg);
        logic [OFFSET_W-1:0] off;
        if (cfg.mode == SMP_QUARTER)
            off = {1'b0, cfg.code};                    // 4*int + quarter
        else
            off = {1'b0, cfg.code[3:0], 1'b0} + 6'd2;  // 2*half + 2
        return off;
    endfunction

endpackage

// File: rtl/sba_timing.sv
module sba_timing
    import sba_pkg::*;
#(
    parameter int TICKS_PER_BIT = 4,
    parameter int BITS_PER_CH   = 8,
    parameter int CHANNELS      = 512,
    localparam int SLOT_W = $clog2(TICKS_PER_BIT),
    localparam int BIT_W  = $clog2(BITS_PER_CH),
    localparam int CH_W   = $clog2(CHANNELS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce,
    input  logic            frame_sync,
    input  dly_cfg_t        cfg,
    output logic            lock,
    output logic            smp_hit,
    output logic            last_bit,
    output logic [CH_W-1:0] chan
);
    localparam int POS_W       = CH_W + BIT_W + SLOT_W;
    localparam int FRAME_TICKS = TICKS_PER_BIT * BITS_PER_CH * CHANNELS;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [BIT_W-1:0]  bitn;
        logic [SLOT_W-1:0] slot;
    } pos_t;

    pos_t              pos_q, pos_cur;
    logic              lock_q;
    logic              boundary;
    logic [POS_W-1:0]  load_val;

    assign boundary = ce && frame_sync;
    assign load_val = POS_W'(FRAME_TICKS - int'(tick_offset(cfg)));

    always_comb begin
        pos_cur = pos_q;
        if (boundary)
            pos_cur = pos_t'(load_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            lock_q <= 1'b0;
        end else if (ce) begin
            pos_q <= pos_t'(POS_W'(pos_cur) + POS_W'(1));
            if (frame_sync)
                lock_q <= 1'b1;
        end
    end

    assign lock     = lock_q;
    assign smp_hit  = ce && lock_q && (pos_cur.slot == '0);
    assign last_bit = (pos_cur.bitn == BIT_W'(BITS_PER_CH - 1));
    assign chan     = pos_cur.ch;

    // R7: the frame position only moves on an enable tick
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(pos_q));

    // R8: alignment is only gained from a boundary strobe that had a tick
    a_r8_lock_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(ce && frame_sync));

endmodule

// File: rtl/sba_shift.sv
module sba_shift #(
    parameter int BITS_PER_CH = 8,
    parameter int CH_W        = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_hit,
    input  logic                   last_bit,
    input  logic [CH_W-1:0]        chan_in,
    input  logic                   sdi,
    output logic                   byte_vld,
    output logic [BITS_PER_CH-1:0] byte_data,
    output logic [CH_W-1:0]        byte_chan
);
    logic [BITS_PER_CH-1:0] sh_q;
    logic [BITS_PER_CH-1:0] sh_next;

    // MSB first: earlier bits move toward the top
    assign sh_next = {sh_q[BITS_PER_CH-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            byte_chan <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (smp_hit) begin
                sh_q <= sh_next;
                if (last_bit) begin
                    byte_vld  <= 1'b1;
                    byte_data <= sh_next;
                    byte_chan <= chan_in;
                end
            end
        end
    end

    // R5: the presented byte and index hold between pulses
    a_r5_data_holds: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |-> $stable(byte_data) && $stable(byte_chan));

endmodule

// File: rtl/serial_bit_aligner.sv
module serial_bit_aligner
    import sba_pkg::*;
#(
    parameter int TICKS_PER_BIT = 4,
    parameter int BITS_PER_CH   = 8,
    parameter int CHANNELS      = 512
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick_en,
    input  logic                          frame_sync,
    input  logic                          sdi,
    input  logic [CODE_W-1:0]             dly_code,
    input  logic                          smp_mode,
    output logic                          byte_vld,
    output logic [BITS_PER_CH-1:0]        byte_data,
    output logic [$clog2(CHANNELS)-1:0]   byte_chan
);
    localparam int CH_W = $clog2(CHANNELS);

    dly_cfg_t        cfg;
    logic            lock;
    logic            smp_hit;
    logic            last_bit;
    logic [CH_W-1:0] chan;

    assign cfg.code = dly_code;
    assign cfg.mode = smp_mode_e'(smp_mode);

    sba_timing #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .BITS_PER_CH   (BITS_PER_CH),
        .CHANNELS      (CHANNELS)
    ) u_timing (
        .clk        (clk),
        .rst        (rst),
        .ce         (tick_en),
        .frame_sync (frame_sync),
        .cfg        (cfg),
        .lock       (lock),
        .smp_hit    (smp_hit),
        .last_bit   (last_bit),
        .chan       (chan)
    );

    sba_shift #(
        .BITS_PER_CH (BITS_PER_CH),
        .CH_W        (CH_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .smp_hit   (smp_hit),
        .last_bit  (last_bit),
        .chan_in   (chan),
        .sdi       (sdi),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_chan (byte_chan)
    );

    // R1: nothing is emitted before alignment is gained
    a_r1_quiet_before_lock: assert property (@(posedge clk) disable iff (rst)
        !lock |=> !byte_vld);

    // R7: a byte only completes on an enable tick
    a_r7_vld_needs_tick: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(tick_en));

    // R5: one pulse per channel; a second only after a boundary re-alignment
    a_r5_one_per_channel: assert property (@(posedge clk) disable iff (rst)
        byte_vld && !(tick_en && frame_sync) |=> !byte_vld);

endmodule

// File: tb/sim_serial_bit_aligner.sv
module sim_serial_bit_aligner;

    localparam int FRAME = 16384;   // ticks per frame
    localparam int NFRM  = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en, frame_sync, sdi, smp_mode;
    logic [4:0] dly_code;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic [8:0] byte_chan;

    always #4 clk = ~clk;   // 125 MHz

    serial_bit_aligner u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .frame_sync(frame_sync),
        .sdi(sdi), .dly_code(dly_code), .smp_mode(smp_mode),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_chan(byte_chan)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string req  = "R1";

    // reference model state
    int  m_lock = 0, m_tif = 0, m_off = 0, m_sh = 0;
    int  e_vld = 0, e_data = 0, e_chan = 0;
    logic [15:0] lfsr = 16'hACE1;
    int  wraps = 0, prev_chan = -1;

    function automatic int ref_offset(int code, int mode);
        if (mode != 0) return code;
        return (code % 16) * 2 + 2;
    endfunction

    task automatic compare();
        vectors++;
        if (byte_vld !== e_vld[0] || byte_data !== e_data[7:0] || byte_chan !== e_chan[8:0]) begin
            errors++;
            $display("FAIL %s t=%0t vld/data/chan actual %0b/%02h/%0d expected %0d/%02h/%0d",
                     req, $time, byte_vld, byte_data, byte_chan, e_vld, e_data, e_chan);
        end
        if (byte_vld === 1'b1) begin
            if (prev_chan == 511 && byte_chan == 0) wraps++;
            prev_chan = int'(byte_chan);
        end
    endtask

    task automatic step(input bit ce, input bit fs);
        int rel;
        int was_locked;
        @(negedge clk);
        compare();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en = ce; frame_sync = fs; sdi = lfsr[0];
        e_vld = 0;
        if (ce) begin
            was_locked = m_lock;
            if (fs) begin
                m_tif = 0; m_off = ref_offset(int'(dly_code), int'(smp_mode)); m_lock = 1;
            end
            if (was_locked != 0) begin
                rel = ((m_tif - m_off) % FRAME + FRAME) % FRAME;
                if (rel % 4 == 0) begin
                    m_sh = ((m_sh << 1) | int'(sdi)) & 255;
                    if ((rel / 4) % 8 == 7) begin
                        e_vld = 1; e_data = m_sh; e_chan = rel / 32;
                    end
                end
            end
            if (m_lock != 0) m_tif++;
        end
    endtask

    initial begin
        rst = 1'b1; tick_en = 0; frame_sync = 0; sdi = 0; dly_code = 0; smp_mode = 1;
        repeat (3) @(negedge clk);
        req = "R1";
        compare();                        // reset state
        rst = 1'b0;
        for (int i = 0; i < 100; i++) step(1, 0);   // R1: no lock yet
        for (int f = 0; f < NFRM; f++) begin
            case (f)
                0: begin req = "R4"; smp_mode = 1; dly_code = 5'b00000; end
                1: begin req = "R2"; smp_mode = 1; dly_code = 5'b11111; end
                2: begin req = "R7"; smp_mode = 0; dly_code = 5'b00111; end
                3: begin req = "R8"; smp_mode = 1; dly_code = 5'b10110; end
                4: begin req = "R3"; smp_mode = 0; dly_code = 5'b11111; end
                5: begin req = "R6"; smp_mode = 1; dly_code = 5'b00100; end
                default: req = "R6";   // keeps the code written during frame 5
            endcase
            for (int t = 0; t < FRAME; t++) begin
                if ((f == 2 || f == 3) && t % 4 == 1)
                    step(0, (f == 3 && t == 8001));   // gap; stray strobe in frame 3
                if (f == 5 && t == 6000) begin
                    smp_mode = 0; dly_code = 5'b01001;   // deferred to frame 6
                end
                step(1, t == 0);
            end
        end
        req = "R5";
        for (int i = 0; i < 300; i++) step(1, 0);
        @(negedge clk);
        compare();
        vectors++;
        if (wraps < NFRM - 1) begin
            errors++;
            $display("FAIL R5 channel wraps 511->0 actual %0d expected >= %0d", wraps, NFRM - 1);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog expired actual running expected finished", req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule